// File: doc/BRIEF.md
# Successive-Approximation Converter Scan Controller

This block is the digital sequencer for a 10-bit successive-approximation converter that watches up to four analog inputs, such as a battery rail. For each conversion it picks one input through a 2-bit select driven to an external analog multiplexer. Each step it presents a trial code to an external DAC, reads one comparator bit back and keeps or drops the trial bit. The settled code is written into one of two result registers.

Software sets the channel, the resolution (2 to 10 bits), single or continuous scanning, and a power-down control. It reads the results and acknowledges them. A one-cycle completion pulse marks each finished conversion. A done flag shows that an unread result is waiting. A sticky overrun flag records that an unread result was overwritten.

Top module: `sar_scan_ctrl`

## Requirements
- R1: While a conversion is in progress, `muxSel` holds the channel that `cfgChannel` had in the cycle the conversion started. While idle or powered down, `muxSel` is 0.
- R2: A conversion at effective resolution N runs exactly N comparison steps, MSB first. The `convDone` pulse appears N+1 cycles after the clock edge that accepts the start, with no settling cycle.
- R3: A `cfgResolution` value below 2 behaves as 2, and a value above 10 behaves as 10.
- R4: `compIn`=1 means the input is at or above `dacCode`. The result is left-aligned, and its 10-N low bits are zero. With an ideal comparator it equals the input voltage code with those low bits cleared.
- R5: With `cfgContinuous`=0, one pulse on `startReq` in idle gives exactly one conversion, and the block then returns to idle (`busy`=0).
- R6: While `cfgContinuous`=1, conversions restart on their own. After it is cleared, the conversion in flight completes and no further conversion starts.
- R7: Results go alternately to `result0` and `result1`. The first result after reset goes to `result0`.
- R8: A completed conversion raises `convDone` for exactly one cycle and sets `doneFlag`. A cycle with `ackRead`=1 and no result write clears `doneFlag`.
- R9: If a result is written while `doneFlag`=1 and `ackRead`=0, `overrunFlag` is set. It stays set until reset, and `ackRead` does not clear it.
- R10: `cfgPowerDown`=1 aborts any conversion. By the next cycle `busy`, `dacCode`, `muxSel` and `analogOn` are 0, no result is written, and `startReq` is ignored. The stored results are kept.
- R11: One settling cycle is inserted before the first step when the channel differs from the previous conversion's channel. It is also inserted for the first conversion after reset or power-down. In those cases `convDone` comes N+2 cycles after the start edge.
- R12: During each step, `dacCode` equals the bits kept so far plus exactly one trial bit, which lies below every kept bit. The trial bit moves down one position per step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgChannel | input | 2 | Channel to convert |
| cfgResolution | input | 4 | Requested resolution in bits, clamped to 2..10 |
| cfgContinuous | input | 1 | 1 = restart conversions automatically |
| cfgPowerDown | input | 1 | 1 = abort and hold analog controls inactive |
| startReq | input | 1 | One-cycle request for a conversion |
| ackRead | input | 1 | Software has read the result; clears the done flag |
| compIn | input | 1 | Comparator output, 1 = input at or above dacCode |
| muxSel | output | 2 | Analog multiplexer select |
| dacCode | output | 10 | Trial code to the DAC |
| analogOn | output | 1 | Power enable for the analog front end |
| busy | output | 1 | A conversion is in progress |
| convDone | output | 1 | One-cycle completion pulse |
| doneFlag | output | 1 | Unread result pending |
| overrunFlag | output | 1 | Sticky: an unread result was overwritten |
| result0 | output | 10 | First result register |
| result1 | output | 10 | Second result register |

## Verification
The bench builds the block with its defaults: 10-bit data, four channels and a minimum resolution of 2. These values make every channel, the full 10-step sequence and both resolution clamps reachable. Driving the comparator from an ideal threshold model gives an exact expected code for every resolution. The bench counts cycles to separate conversions that need a settling cycle from those that do not.

// File: rtl/sar_scan_pkg.sv
package sar_scan_pkg;
  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic load;    // a new conversion is accepted this cycle
    logic step;    // a comparison step is executed this cycle
    logic finish;  // this step is the last one of the conversion
  } sarStrobeT;
endpackage

// File: rtl/sar_scan_fsm.sv
module sar_scan_fsm
  import sar_scan_pkg::*;
#(
  parameter int DATA_W   = 10,
  parameter int CH_COUNT = 4,
  parameter int MIN_RES  = 2,
  localparam int CH_W    = $clog2(CH_COUNT),
  localparam int RES_W   = $clog2(DATA_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CH_W-1:0]  cfgChannel,
  input  logic [RES_W-1:0] cfgResolution,
  input  logic             cfgContinuous,
  input  logic             cfgPowerDown,
  input  logic             startReq,
  output sarStrobeT        strb,
  output logic             busy,
  output logic [CH_W-1:0]  muxSel
);
  typedef enum logic [1:0] {ST_IDLE, ST_SETTLE, ST_STEP} stateT;
  stateT            state;
  logic [CH_W-1:0]  chanLat;
  logic             chanValid;
  logic [RES_W-1:0] resLat, stepsLeft, resClamped;
  logic             startNow, needSettle;

  always_comb begin
    if (cfgResolution < RES_W'(MIN_RES))     resClamped = RES_W'(MIN_RES);
    else if (cfgResolution > RES_W'(DATA_W)) resClamped = RES_W'(DATA_W);
    else                                     resClamped = cfgResolution;
  end

  assign startNow    = (state == ST_IDLE) && (startReq || cfgContinuous) && !cfgPowerDown;
  assign needSettle  = !chanValid || (cfgChannel != chanLat);
  assign strb.load   = startNow;
  assign strb.step   = (state == ST_STEP) && !cfgPowerDown;
  assign strb.finish = strb.step && (stepsLeft == RES_W'(1));
  assign busy        = (state != ST_IDLE);
  assign muxSel      = (busy && !cfgPowerDown) ? chanLat : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      chanLat   <= '0;
      chanValid <= 1'b0;
      resLat    <= RES_W'(MIN_RES);
      stepsLeft <= '0;
    end else if (cfgPowerDown) begin
      state     <= ST_IDLE;
      chanValid <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (startNow) begin
          chanLat   <= cfgChannel;
          chanValid <= 1'b1;
          resLat    <= resClamped;
          stepsLeft <= resClamped;
          state     <= needSettle ? ST_SETTLE : ST_STEP;
        end
        ST_SETTLE: state <= ST_STEP;
        ST_STEP: begin
          stepsLeft <= stepsLeft - RES_W'(1);
          if (stepsLeft == RES_W'(1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Independent step tally used only by the checks below.
  logic [RES_W-1:0] stepsSeen;
  always_ff @(posedge clk) begin
    if (!rstN || strb.load) stepsSeen <= '0;
    else if (strb.step)     stepsSeen <= stepsSeen + RES_W'(1);
  end

  assert_step_count_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |-> (stepsSeen + RES_W'(1) == resLat));
  assert_pd_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    cfgPowerDown |=> !busy);
  assert_mux_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !cfgPowerDown && !$past(cfgPowerDown)) |-> $stable(muxSel));
  assert_res_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (resLat >= RES_W'(MIN_RES) && resLat <= RES_W'(DATA_W)));
endmodule

// File: rtl/sar_scan_dp.sv
module sar_scan_dp
  import sar_scan_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  sarStrobeT         strb,
  input  logic              compIn,
  input  logic              ackRead,
  output logic [DATA_W-1:0] dacCode,
  output logic [DATA_W-1:0] result0,
  output logic [DATA_W-1:0] result1,
  output logic              doneFlag,
  output logic              overrunFlag,
  output logic              convDone
);
  logic [DATA_W-1:0] acc, trialBit, trialCode, finalCode;
  logic [DATA_W-1:0] resultReg [2];
  logic              writeSel;

  assign trialCode = acc | trialBit;
  assign finalCode = compIn ? trialCode : acc;
  assign dacCode   = strb.step ? trialCode : '0;
  assign result0   = resultReg[0];
  assign result1   = resultReg[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc      <= '0;
      trialBit <= '0;
    end else if (strb.load) begin
      acc      <= '0;
      trialBit <= {1'b1, {(DATA_W-1){1'b0}}};
    end else if (strb.step) begin
      if (compIn) acc <= trialCode;
      trialBit <= trialBit >> 1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultReg[0] <= '0;
      resultReg[1] <= '0;
      writeSel     <= 1'b0;
      doneFlag     <= 1'b0;
      overrunFlag  <= 1'b0;
      convDone     <= 1'b0;
    end else begin
      convDone <= strb.finish;
      if (strb.finish) begin
        resultReg[writeSel] <= finalCode;
        writeSel            <= ~writeSel;
        doneFlag            <= 1'b1;
        if (doneFlag && !ackRead) overrunFlag <= 1'b1;
      end else if (ackRead) begin
        doneFlag <= 1'b0;
      end
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> (convDone && doneFlag));
  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    convDone |=> !convDone);
  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    overrunFlag |=> overrunFlag);
  assert_trial_below_R12: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |-> ($onehot(trialBit) && ((acc & ~(trialBit - DATA_W'(1))) & trialBit) == '0
                   && (acc & (trialBit - DATA_W'(1))) == '0));
endmodule

// File: rtl/sar_scan_ctrl.sv
module sar_scan_ctrl
  import sar_scan_pkg::*;
#(
  parameter int DATA_W   = 10,
  parameter int CH_COUNT = 4,
  parameter int MIN_RES  = 2,
  localparam int CH_W    = $clog2(CH_COUNT),
  localparam int RES_W   = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CH_W-1:0]   cfgChannel,
  input  logic [RES_W-1:0]  cfgResolution,
  input  logic              cfgContinuous,
  input  logic              cfgPowerDown,
  input  logic              startReq,
  input  logic              ackRead,
  input  logic              compIn,
  output logic [CH_W-1:0]   muxSel,
  output logic [DATA_W-1:0] dacCode,
  output logic              analogOn,
  output logic              busy,
  output logic              convDone,
  output logic              doneFlag,
  output logic              overrunFlag,
  output logic [DATA_W-1:0] result0,
  output logic [DATA_W-1:0] result1
);
  sarStrobeT strb;

  assign analogOn = !cfgPowerDown;

  sar_scan_fsm #(.DATA_W(DATA_W), .CH_COUNT(CH_COUNT), .MIN_RES(MIN_RES)) u_fsm (
    .clk(clk), .rstN(rstN), .cfgChannel(cfgChannel), .cfgResolution(cfgResolution),
    .cfgContinuous(cfgContinuous), .cfgPowerDown(cfgPowerDown), .startReq(startReq),
    .strb(strb), .busy(busy), .muxSel(muxSel)
  );

  sar_scan_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .compIn(compIn), .ackRead(ackRead),
    .dacCode(dacCode), .result0(result0), .result1(result1),
    .doneFlag(doneFlag), .overrunFlag(overrunFlag), .convDone(convDone)
  );
endmodule

// File: tb/sar_scan_ctrl_tb.sv
module sar_scan_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // channel, requested resolution, input code
  localparam int VEC [NVEC][3] = '{
    '{0, 10, 677}, '{0, 8, 677}, '{1, 2, 1023}, '{1, 5, 0},
    '{2, 10, 512}, '{3, 3, 700}, '{3, 10, 1023}, '{2, 7, 511}};

  logic clk = 0, rstN = 0;
  logic [1:0] cfgChannel = 0;
  logic [3:0] cfgResolution = 10;
  logic cfgContinuous = 0, cfgPowerDown = 0, startReq = 0, ackRead = 0;
  logic compIn;
  logic [1:0] muxSel;
  logic [9:0] dacCode, result0, result1;
  logic analogOn, busy, convDone, doneFlag, overrunFlag;
  logic [9:0] vinArr [4];

  int checks = 0, errors = 0;
  int lastCh = 0;
  bit chValid = 0;
  bit slot = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign compIn = (vinArr[muxSel] >= dacCode);

  sar_scan_ctrl u_dut (
    .clk(clk), .rstN(rstN), .cfgChannel(cfgChannel), .cfgResolution(cfgResolution),
    .cfgContinuous(cfgContinuous), .cfgPowerDown(cfgPowerDown), .startReq(startReq),
    .ackRead(ackRead), .compIn(compIn), .muxSel(muxSel), .dacCode(dacCode),
    .analogOn(analogOn), .busy(busy), .convDone(convDone), .doneFlag(doneFlag),
    .overrunFlag(overrunFlag), .result0(result0), .result1(result1));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expCode(input int vin, input int effRes);
    return vin & ~((1 << (10 - effRes)) - 1);
  endfunction

  task automatic runConv(input int ch, input int res, input int effRes, input int vin, input bit doAck);
    int cyc, expCyc;
    bit settle;
    logic [9:0] got;
    settle = !chValid || (ch != lastCh);
    expCyc = effRes + 1 + (settle ? 1 : 0);
    vinArr[ch] = 10'(vin);
    cfgChannel = 2'(ch);
    cfgResolution = 4'(res);
    startReq = 1;
    @(negedge clk);
    startReq = 0;
    cyc = 1;
    chk(busy && muxSel == 2'(ch), "R1", int'(muxSel), ch);
    while (!convDone && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == expCyc, settle ? "R11" : "R2", cyc, expCyc);
    got = slot ? result1 : result0;
    chk(got == 10'(expCode(vin, effRes)), effRes != res ? "R3" : "R4", int'(got), expCode(vin, effRes));
    chk(doneFlag, "R8", int'(doneFlag), 1);
    lastCh = ch;
    chValid = 1;
    slot = ~slot;
    if (doAck) begin
      ackRead = 1;
      @(negedge clk);
      ackRead = 0;
      chk(!doneFlag && !convDone, "R8", int'(doneFlag), 0);
      chk(!busy, "R5", int'(busy), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int pulses;
    logic [9:0] keep0, keep1;
    for (int i = 0; i < 4; i++) vinArr[i] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !doneFlag && !overrunFlag && !convDone, "R8", int'(doneFlag), 0);
    chk(result0 == 0 && result1 == 0 && dacCode == 0 && muxSel == 0, "R1", int'(muxSel), 0);
    rstN = 1;
    @(negedge clk);

    // Vector table: R2 R4 R7 R11
    for (int v = 0; v < NVEC; v++)
      runConv(VEC[v][0], VEC[v][1], VEC[v][1], VEC[v][2], 1'b1);

    // Resolution clamps: R3
    runConv(3, 0, 2, 700, 1'b1);
    runConv(3, 15, 10, 700, 1'b1);
    runConv(3, 1, 2, 1000, 1'b1);

    // Continuous scanning: R6
    vinArr[1] = 10'd300;
    cfgChannel = 2'd1;
    cfgResolution = 4'd4;
    ackRead = 1;
    cfgContinuous = 1;
    pulses = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (convDone) begin
        pulses++;
        chk((slot ? result1 : result0) == 10'd256, "R6", int'(slot ? result1 : result0), 256);
        slot = ~slot;
      end
    end
    chk(pulses >= 3, "R6", pulses, 3);
    cfgContinuous = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (convDone) slot = ~slot;
    end
    chk(!busy, "R6", int'(busy), 0);
    pulses = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (convDone) pulses++;
    end
    chk(pulses == 0, "R6", pulses, 0);
    ackRead = 0;
    chValid = 1;
    lastCh = 1;

    // Power-down abort: R10
    keep0 = result0;
    keep1 = result1;
    vinArr[2] = 10'd800;
    cfgChannel = 2'd2;
    cfgResolution = 4'd10;
    startReq = 1;
    @(negedge clk);
    startReq = 0;
    repeat (3) @(negedge clk);
    cfgPowerDown = 1;
    @(negedge clk);
    chk(!busy && dacCode == 0 && muxSel == 0 && !analogOn, "R10", int'(busy), 0);
    startReq = 1;
    @(negedge clk);
    startReq = 0;
    pulses = 0;
    for (int c = 0; c < 15; c++) begin
      @(negedge clk);
      if (convDone || busy) pulses++;
    end
    chk(pulses == 0, "R10", pulses, 0);
    chk(result0 == keep0 && result1 == keep1 && !doneFlag, "R10", int'(result0), int'(keep0));
    cfgPowerDown = 0;
    chValid = 0;
    @(negedge clk);
    runConv(2, 10, 10, 800, 1'b1);

    // Overrun: R9
    chk(!overrunFlag, "R9", int'(overrunFlag), 0);
    runConv(2, 6, 6, 400, 1'b0);
    chk(!overrunFlag, "R9", int'(overrunFlag), 0);
    runConv(2, 6, 6, 401, 1'b0);
    @(negedge clk);
    chk(overrunFlag, "R9", int'(overrunFlag), 1);
    ackRead = 1;
    @(negedge clk);
    ackRead = 0;
    @(negedge clk);
    chk(overrunFlag && !doneFlag, "R9", int'(overrunFlag), 1);

    // Reset clears everything
    rstN = 0;
    @(negedge clk);
    chk(!overrunFlag && result0 == 0 && result1 == 0, "R7", int'(result0), 0);
    rstN = 1;
    slot = 0;
    chValid = 0;
    @(negedge clk);
    runConv(0, 10, 10, 5, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule